// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block collects eight interrupt request lines and presents one interrupt output to a processor. It keeps a request register, an in-service register and a mask register. Priority is fixed: line 0 is the highest and line 7 the lowest. A line may raise the output only when it is unmasked and its priority is above every level already in service. Each line can be set to trigger on a rising edge or on a high level.

Software services an interrupt in one of two ways. In the first, the processor issues a two-strobe acknowledge. The first strobe takes the winning line into service. The second strobe returns an 8-bit vector built from a programmable 5-bit base and the 3-bit level. In the second way, software writes a poll command. The next register read then acts as the acknowledge and returns a status byte instead of a vector. If the winning request disappears before the first strobe, the controller returns a default line-7 vector. In-service bits are cleared by a non-specific end-of-interrupt command, or automatically at the second strobe when auto-EOI is enabled.

All registers sit behind a byte-wide port with four addresses. Address 0 takes command words and returns the request register or the in-service register. Address 1 is the mask. Address 2 is the trigger mode. Address 3 reads back the configuration.

Top module: `intc8_top`

## Requirements
- R1: After synchronous reset, the request, in-service, mask and trigger-mode registers are all zero, the vector base is zero, auto-EOI is off, poll is disarmed, int_out is 0 and vec_valid is 0.
- R2: With trigger-mode bit 0 (edge), a low-to-high transition on a line latches a request. A line held high latches no second request. A latched edge request is dropped if the input falls before the request is taken.
- R3: With trigger-mode bit 1 (level), the request follows the input. A request still high when its in-service bit is cleared raises int_out again.
- R4: Mask bit 1 excludes its line from priority resolution and from int_out, but the line keeps its latched request. When the bit is cleared, the request takes part again. The mask is written and read at address 1.
- R5: int_out is 1 when an unmasked request has a lower line number than every set in-service bit. Line 0 has the highest priority.
- R6: The acknowledge is two single-cycle pulses on ack. The first pulse sets the in-service bit of the winning line and clears its edge request. In the cycle after the second pulse, vec_valid is 1 and vec_out equals base*8 + level.
- R7: If no request is pending at the first pulse, the vector after the second pulse is base*8 + 7, and no in-service bit is set.
- R8: A write to address 0 with bits [7:3] = 00001 is an operation word. Bit 0 of this word arms poll. The next read at any address then returns bit 7 = pending and bits [2:0] = the winning level, with bits [6:3] zero. That read also sets the in-service bit of the winning line. With nothing pending, the read returns 0x00.
- R9: While poll is armed, request recognition is frozen and int_out is 0. Edges that arrive in that window are recognised after the poll read.
- R10: Bit 1 of an operation word is a non-specific EOI. It clears the lowest-numbered (highest-priority) set in-service bit.
- R11: A write to address 0 with bits [7:6] = 11 is a configuration word: bits [4:0] give the vector base and bit 5 enables auto-EOI. With auto-EOI on, the in-service bit set at the first pulse is cleared at the second pulse. Address 3 reads {2'b00, auto-EOI, base}.
- R12: A read at address 0 returns the in-service register when bit 2 of the last operation word was 1, and the request register when it was 0. Address 2 reads and writes the trigger mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while reg_rd is high |
| ack | input | 1 | Acknowledge strobe, one pulse per phase |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector from the second acknowledge pulse |
| vec_valid | output | 1 | vec_out valid for one cycle |

## Verification
The bench drives a raising line while poll is armed and expects the original level back. A design that did not freeze recognition would report the newer, higher line. The bench also drops a request before the first acknowledge pulse and expects vector base*8 + 7 with the in-service register still empty. A design that skipped the default would return a stale level or set bit 7. It holds a level-mode line high across an EOI to see int_out come back, and holds an edge-mode line high to see it stay low. A design that confused the two modes either loses the retrigger or fires repeatedly. Finally, it sets two in-service bits and issues one EOI, to catch a design that clears the wrong bit or both bits.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
    localparam int NL = 8;
    localparam int LW = $clog2(NL);
    localparam int DW = 8;
    localparam int BW = DW - LW;

    typedef struct packed {
        logic          found;
        logic [LW-1:0] lvl;
    } pick_t;

    typedef enum logic [1:0] {
        A_CMD  = 2'd0,
        A_MASK = 2'd1,
        A_TRIG = 2'd2,
        A_CFG  = 2'd3
    } addr_e;

    function automatic pick_t pick_lowest(input logic [NL-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.lvl   = LW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [NL-1:0] lvl_bit(input logic [LW-1:0] l);
        return NL'(1) << l;
    endfunction
endpackage

// File: rtl/intc8_req.sv
module intc8_req
    import intc8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] irq_in,
    input  logic [NL-1:0] trig,
    input  logic          freeze,
    input  logic [NL-1:0] clr,
    output logic [NL-1:0] irr
);
    logic [NL-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr    <= '0;
        end else if (freeze) begin
            irr <= irr & ~clr;
        end else begin
            prev_q <= irq_in;
            for (int i = 0; i < NL; i++) begin
                if (trig[i])
                    irr[i] <= irq_in[i];
                else
                    irr[i] <= ((irq_in[i] & ~prev_q[i]) | (irr[i] & irq_in[i])) & ~clr[i];
            end
        end
    end

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && clr == '0) |=> $stable(irr));

    for (genvar g = 0; g < NL; g++) begin : g_line
        // R2
        edge_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
            (!freeze && !trig[g] && prev_q[g] && irq_in[g] && !irr[g]) |=> !irr[g]);
    end
endmodule

// File: rtl/intc8_resolve.sv
module intc8_resolve
    import intc8_pkg::*;
(
    input  logic [NL-1:0] irr,
    input  logic [NL-1:0] mask,
    input  logic [NL-1:0] isr,
    output pick_t         pend,
    output pick_t         itop
);
    logic [NL-1:0] above;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NL; i++) begin
            seen     = seen | isr[i];
            above[i] = ~seen;
        end
        pend = pick_lowest(irr & ~mask & above);
        itop = pick_lowest(isr);
    end
endmodule

// File: rtl/intc8_ack.sv
module intc8_ack
    import intc8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ack,
    input  pick_t         pend,
    input  logic [BW-1:0] base,
    input  logic          aeoi,
    output logic          take,
    output logic          auto_clr,
    output logic [LW-1:0] auto_lvl,
    output logic          second,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid
);
    logic          phase_q, spur_q;
    logic [LW-1:0] lvl_q;

    assign second   = phase_q;
    assign take     = ack && !phase_q && pend.found;
    assign auto_clr = ack && phase_q && aeoi && !spur_q;
    assign auto_lvl = lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            spur_q    <= 1'b0;
            lvl_q     <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            if (ack && !phase_q) begin
                phase_q <= 1'b1;
                spur_q  <= !pend.found;
                lvl_q   <= pend.found ? pend.lvl : '1;
            end else if (ack && phase_q) begin
                phase_q   <= 1'b0;
                vec_out   <= {base, lvl_q};
                vec_valid <= 1'b1;
            end
        end
    end

    // R6
    vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && phase_q) |=> (vec_valid && vec_out[DW-1:LW] == $past(base)));
    // R7
    spur_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && phase_q && spur_q) |=> (vec_out[LW-1:0] == '1));
endmodule

// File: rtl/intc8_top.sv
module intc8_top
    import intc8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] irq_in,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          ack,
    output logic          int_out,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid
);
    logic [NL-1:0] mask_q, trig_q, isr_q, irr, clr_req;
    logic [BW-1:0] base_q;
    logic          aeoi_q, rdsel_q, poll_q;
    pick_t         pend, itop;
    logic          ack_take, auto_clr, second;
    logic [LW-1:0] auto_lvl;

    logic cmd_wr, is_cfg, is_op, eoi_cmd, poll_rd, take_any;
    assign cmd_wr   = reg_wr && (addr_e'(reg_addr) == A_CMD);
    assign is_cfg   = cmd_wr && (wr_data[7:6] == 2'b11);
    assign is_op    = cmd_wr && (wr_data[7:3] == 5'b00001);
    assign eoi_cmd  = is_op && wr_data[1];
    assign poll_rd  = reg_rd && poll_q;
    assign take_any = ack_take || (poll_rd && pend.found);
    assign clr_req  = take_any ? lvl_bit(pend.lvl) : '0;
    assign int_out  = pend.found && !poll_q;

    intc8_req u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig_q),
        .freeze(poll_q), .clr(clr_req), .irr(irr)
    );

    intc8_resolve u_res (
        .irr(irr), .mask(mask_q), .isr(isr_q), .pend(pend), .itop(itop)
    );

    intc8_ack u_ack (
        .clk(clk), .rst(rst), .ack(ack), .pend(pend), .base(base_q),
        .aeoi(aeoi_q), .take(ack_take), .auto_clr(auto_clr),
        .auto_lvl(auto_lvl), .second(second), .vec_out(vec_out),
        .vec_valid(vec_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            trig_q  <= '0;
            base_q  <= '0;
            aeoi_q  <= 1'b0;
            rdsel_q <= 1'b0;
            poll_q  <= 1'b0;
        end else begin
            if (reg_wr && addr_e'(reg_addr) == A_MASK) mask_q <= wr_data;
            if (reg_wr && addr_e'(reg_addr) == A_TRIG) trig_q <= wr_data;
            if (is_cfg) begin
                base_q <= wr_data[BW-1:0];
                aeoi_q <= wr_data[5];
            end
            if (is_op) rdsel_q <= wr_data[2];
            if (poll_rd)    poll_q <= 1'b0;
            else if (is_op) poll_q <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else begin
            logic [NL-1:0] n;
            n = isr_q;
            if (eoi_cmd && itop.found) n = n & ~lvl_bit(itop.lvl);
            if (auto_clr)              n = n & ~lvl_bit(auto_lvl);
            if (take_any)              n = n | lvl_bit(pend.lvl);
            isr_q <= n;
        end
    end

    always_comb begin
        if (poll_q) begin
            rd_data = {pend.found, {(DW-1-LW){1'b0}}, pend.lvl};
        end else begin
            case (addr_e'(reg_addr))
                A_CMD:   rd_data = rdsel_q ? isr_q : irr;
                A_MASK:  rd_data = mask_q;
                A_TRIG:  rd_data = trig_q;
                default: rd_data = {2'b00, aeoi_q, base_q};
            endcase
        end
    end

    // R6
    take_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !eoi_cmd) |=> isr_q[$past(pend.lvl)]);
    // R7
    spur_no_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !second && !pend.found && !cmd_wr && !reg_rd) |=> $stable(isr_q));
    // R10
    eoi_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_cmd && !ack && !reg_rd && isr_q != '0) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));
    // R9
    poll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(is_op && wr_data[0] && !reg_rd) |-> !int_out);
endmodule

// File: tb/sim_intc8_top.sv
module sim_intc8_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, vec_out;
    logic       int_out, vec_valid;

    int checks = 0, errs = 0;
    logic [7:0] b, v;
    logic       vv;

    always #10 clk = ~clk;

    intc8_top u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
        .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // {irq pattern, mask, expected poll byte}
    localparam logic [23:0] TBL [8] = '{
        {8'h01, 8'h00, 8'h80},
        {8'h80, 8'h00, 8'h87},
        {8'h0C, 8'h00, 8'h82},
        {8'hF0, 8'h10, 8'h85},
        {8'hFF, 8'hFE, 8'h80},
        {8'h04, 8'h04, 8'h00},
        {8'h00, 8'h00, 8'h00},
        {8'h60, 8'h00, 8'h85}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] vo, output logic vld);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        @(negedge clk); ack = 1'b1;
        @(posedge clk); #1 vo = vec_out; vld = vec_valid;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] p);
        @(negedge clk); irq_in = p;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1 chk("R1 int_out", {7'b0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
        rd(2'd0, b); chk("R1 request reg", b, 8'h00);
        rd(2'd1, b); chk("R1 mask", b, 8'h00);
        rd(2'd2, b); chk("R1 trigger", b, 8'h00);
        rd(2'd3, b); chk("R1 config", b, 8'h00);

        // R8 R4 R5 table of poll results
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, TBL[k][15:8]);
            set_irq(TBL[k][23:16]);
            wr(2'd0, 8'h09);
            rd(2'd0, b); chk("R8 poll byte", b, TBL[k][7:0]);
            set_irq(8'h00);
            wr(2'd0, 8'h0E);
            rd(2'd0, b); chk("R10 isr after eoi", b, 8'h00);
            wr(2'd0, 8'h08);
        end
        wr(2'd1, 8'h00);

        // R9 freeze and quiet output
        set_irq(8'h08);
        #1 chk("R5 int_out raised", {7'b0, int_out}, 8'h01);
        wr(2'd0, 8'h09);
        #1 chk("R9 int_out low while armed", {7'b0, int_out}, 8'h00);
        set_irq(8'h0A);
        rd(2'd0, b); chk("R9 frozen level", b, 8'h83);
        @(negedge clk);
        #1 chk("R9 late edge seen", {7'b0, int_out}, 8'h01);
        wr(2'd0, 8'h09);
        rd(2'd0, b); chk("R8 second poll", b, 8'h81);
        wr(2'd0, 8'h0E);
        rd(2'd0, b); chk("R10 highest isr cleared", b, 8'h08);
        wr(2'd0, 8'h0E);
        rd(2'd0, b); chk("R10 last isr cleared", b, 8'h00);
        set_irq(8'h00);

        // R6 acknowledge vector
        wr(2'd0, 8'hCA);
        set_irq(8'h20);
        do_ack(v, vv);
        chk("R6 vector", v, 8'h55);
        chk("R6 vec_valid", {7'b0, vv}, 8'h01);
        rd(2'd0, b); chk("R6 isr set", b, 8'h20);
        #1 chk("R6 int_out low in service", {7'b0, int_out}, 8'h00);
        wr(2'd0, 8'h0E);
        #1 chk("R2 held edge no rerequest", {7'b0, int_out}, 8'h00);
        set_irq(8'h00);

        // R2 R7 vanished edge request
        set_irq(8'h10);
        set_irq(8'h00);
        do_ack(v, vv);
        chk("R7 default vector edge", v, 8'h57);
        rd(2'd0, b); chk("R7 no isr", b, 8'h00);

        // R3 level mode
        wr(2'd2, 8'h40);
        rd(2'd2, b); chk("R12 trigger readback", b, 8'h40);
        set_irq(8'h40);
        #1 chk("R3 level raises", {7'b0, int_out}, 8'h01);
        do_ack(v, vv);
        chk("R3 level vector", v, 8'h56);
        #1 chk("R3 low in service", {7'b0, int_out}, 8'h00);
        wr(2'd0, 8'h0E);
        @(negedge clk);
        #1 chk("R3 retrigger after eoi", {7'b0, int_out}, 8'h01);
        set_irq(8'h00);
        #1 chk("R3 follows input low", {7'b0, int_out}, 8'h00);
        set_irq(8'h40);
        set_irq(8'h00);
        do_ack(v, vv);
        chk("R7 default vector level", v, 8'h57);
        rd(2'd0, b); chk("R7 isr empty", b, 8'h00);
        wr(2'd2, 8'h00);

        // R4 mask retains request
        wr(2'd1, 8'h08);
        rd(2'd1, b); chk("R4 mask readback", b, 8'h08);
        set_irq(8'h08);
        #1 chk("R4 masked quiet", {7'b0, int_out}, 8'h00);
        wr(2'd1, 8'h00);
        #1 chk("R4 request kept", {7'b0, int_out}, 8'h01);
        set_irq(8'h00);

        // R11 auto-EOI
        wr(2'd0, 8'hEA);
        rd(2'd3, b); chk("R11 config readback", b, 8'h2A);
        set_irq(8'h04);
        do_ack(v, vv);
        chk("R11 vector", v, 8'h52);
        rd(2'd0, b); chk("R11 isr auto cleared", b, 8'h00);
        set_irq(8'h00);

        // R12 request register read
        wr(2'd0, 8'h08);
        set_irq(8'h81);
        rd(2'd0, b); chk("R12 request read", b, 8'h81);
        set_irq(8'h00);
        rd(2'd0, b); chk("R12 request cleared", b, 8'h00);

        summary();
    end
endmodule